// File: doc/BRIEF.md
# Edge-Selectable Port Interrupt Controller

This block is the interrupt front end of a small 8-bit microcontroller core. It watches an 8-bit input port and turns a chosen edge on each pin into a per-pin pending flag. It also counts an 8-bit real-time counter and produces a one-cycle timer request each time that counter wraps from its top value back to zero. Software reaches the configuration and state through a small register bus:

- a write strobe with an address and write data;
- a combinational read data path.

Two request outputs are driven. `irq` combines the unmasked pending pins with the enabled timer wrap. `wake` carries only the unmasked pending pins, for the sleep controller.

Each pin is synchronised by two flops. An edge is then found by comparing the synchronised level with its value one cycle earlier. The pin mask is active-low and comes up with every pin masked. The edge choice comes up as falling on every pin. The pending register has no defined reset value, so software clears it before unmasking any pin. The timer source keeps no flag: its request lasts exactly the one cycle after the wrap.

Top module: `pic_front`

## Requirements
- R1: After reset the pin mask register reads 0xFF, the edge-select register reads 0xFF, the option register reads 0x00 and the counter reads 0x00.
- R2: Register addresses are: 0 pin mask, 1 edge select, 2 pending, 3 option (bit 0 = timer interrupt enable, 1 enables), 4 counter. A write with `wr_en` high stores `wdata` at the next clock edge, and `rdata` shows the addressed register combinationally. Any other address reads 0.
- R3: With edge-select bit i = 0, a rising level change on `pin_in[i]` sets pending bit i at the third rising clock edge after the change, and not before.
- R4: With edge-select bit i = 1, a falling level change on `pin_in[i]` sets pending bit i with the same three-edge latency.
- R5: A qualifying edge sets its pending bit even when that pin is masked. A masked pending pin raises neither `irq` nor `wake`.
- R6: Mask bit i = 0 enables pin i. `irq` and `wake` are high whenever some pending bit has its mask bit at 0.
- R7: A write to the pending register loads `wdata`. An edge detected in the same cycle still sets its bit.
- R8: Pending bits stay set until software writes them. An edge of the unselected direction sets nothing.
- R9: The counter adds one at each clock edge where `tick` is high, and a counter write takes precedence over `tick`. A tick at 0xFF wraps the counter to 0x00. With option bit 0 set, `irq` is high for exactly the following cycle.
- R10: With option bit 0 clear, a wrap raises no `irq`. There is no timer pending flag, so no request remains after the one-cycle wrap window.
- R11: `wake` never reflects the timer. Whenever `wake` is high, `irq` is high too.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | 8 | Asynchronous port pins watched for edges |
| tick | input | 1 | Counter increment strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data |
| irq | output | 1 | Combined interrupt request |
| wake | output | 1 | Wakeup request from unmasked pending pins |

## Verification
The hardest case to reach from the ports is a pending-register write landing in the very cycle an edge is detected. The edge becomes visible only after two synchroniser stages, so the write has to be timed against that pipeline. The bench drives a pin change at a known time, counts two rising edges, and only then asserts a clearing write. It then checks that the edge's bit survives while the others clear. Long random runs with frequent writes and pin toggles then hit the same collision many times, while a cycle-level reference model checks every output.

// File: rtl/pic_pkg.sv
package pic_pkg;

  typedef enum logic [2:0] {
    RA_MASK = 3'd0,
    RA_ESEL = 3'd1,
    RA_PEND = 3'd2,
    RA_OPT  = 3'd3,
    RA_CNT  = 3'd4
  } reg_addr_e;

  localparam int OPT_TMR_EN_BIT = 0;

endpackage

// File: rtl/pin_edge.sv
module pin_edge #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  input  logic [N-1:0] fall_sel,
  output logic [N-1:0] hit
);

  logic [N-1:0] s0_q, s1_q, prev_q;

  // qualifying edge for one pin: 1 selects falling, 0 selects rising
  function automatic logic edge_qual(input logic now_v, input logic was_v, input logic fall);
    return fall ? (was_v & ~now_v) : (now_v & ~was_v);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q   <= '0;
      s1_q   <= '0;
      prev_q <= '0;
    end else begin
      s0_q   <= pin_in;
      s1_q   <= s0_q;
      prev_q <= s1_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign hit[i] = edge_qual(s1_q[i], prev_q[i], fall_sel[i]);
  end

endmodule

// File: rtl/pend_bank.sv
module pend_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] hit,
  output logic [N-1:0] pend_q
);

  // no reset: contents are undefined until software writes them
  always_ff @(posedge clk) begin
    pend_q <= (wr ? wdata : pend_q) | hit;
  end

  p_edge_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((pend_q & $past(hit)) == $past(hit)));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

endmodule

// File: rtl/rtc_wrap.sv
module rtc_wrap #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q,
  output logic         wrap_q
);

  localparam logic [W-1:0] CNT_TOP = '1;

  function automatic logic [W-1:0] cnt_next(input logic [W-1:0] c);
    return c + W'(1);
  endfunction

  logic at_top;
  assign at_top = (cnt_q == CNT_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      if (wr)        cnt_q <= wdata;
      else if (tick) cnt_q <= cnt_next(cnt_q);
      wrap_q <= tick & ~wr & at_top;
    end
  end

  p_wrap_to_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr && cnt_q == CNT_TOP) |=> (wrap_q && cnt_q == '0));

  p_wrap_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |=> !wrap_q);

endmodule

// File: rtl/pic_front.sv
module pic_front
  import pic_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pin_in,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] rdata,
  output logic              irq,
  output logic              wake
);

  logic [PORT_W-1:0] mask_q, esel_q, opt_q, pend_q, hit;
  logic [CNT_W-1:0]  cnt_q;
  logic              wrap_q;
  logic              wr_pend, wr_cnt, tmr_req, pin_req;

  assign wr_pend = wr_en && (addr == RA_PEND);
  assign wr_cnt  = wr_en && (addr == RA_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      esel_q <= '1;
      opt_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        RA_MASK: mask_q <= wdata;
        RA_ESEL: esel_q <= wdata;
        RA_OPT:  opt_q  <= wdata;
        default: ;
      endcase
    end
  end

  pin_edge #(.N(PORT_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .fall_sel(esel_q), .hit(hit)
  );

  pend_bank #(.N(PORT_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .wr(wr_pend), .wdata(wdata), .hit(hit), .pend_q(pend_q)
  );

  rtc_wrap #(.W(CNT_W)) u_rtc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr(wr_cnt),
    .wdata(wdata[CNT_W-1:0]), .cnt_q(cnt_q), .wrap_q(wrap_q)
  );

  assign pin_req = |(pend_q & ~mask_q);
  assign tmr_req = wrap_q & opt_q[OPT_TMR_EN_BIT];
  assign wake    = pin_req;
  assign irq     = pin_req | tmr_req;

  always_comb begin
    case (addr)
      RA_MASK: rdata = mask_q;
      RA_ESEL: rdata = esel_q;
      RA_PEND: rdata = pend_q;
      RA_OPT:  rdata = opt_q;
      RA_CNT:  rdata = PORT_W'(cnt_q);
      default: rdata = '0;
    endcase
  end

  p_wake_in_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> irq);

  p_all_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1 && !tmr_req) |-> !irq);

  p_reset_vals_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (mask_q == '1 && esel_q == '1 && opt_q == '0));

endmodule

// File: tb/sim_pic_front.sv
`timescale 1ns/1ps
module sim_pic_front;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_in = '0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, wake;

  always #2.5 clk = ~clk;

  pic_front u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .wake(wake)
  );

  int vectors = 0;
  int fails   = 0;
  bit chk_on  = 0;
  bit done    = 0;

  // reference state
  logic [7:0] m_s0, m_s1, m_prev, m_en, m_esel, m_opt, m_cnt, m_pend;
  logic       m_wrap;

  function automatic logic [7:0] want_hit(input logic [7:0] now_v, input logic [7:0] was_v,
                                          input logic [7:0] fall);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = (now_v[i] != was_v[i]) && (now_v[i] == ~fall[i]);
    return r;
  endfunction

  function automatic logic want_wake(input logic [7:0] p, input logic [7:0] en);
    for (int i = 0; i < 8; i++)
      if (p[i] && !en[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [7:0] want_read(input logic [2:0] a);
    case (a)
      3'd0: return m_en;
      3'd1: return m_esel;
      3'd2: return m_pend;
      3'd3: return m_opt;
      3'd4: return m_cnt;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s0 <= '0; m_s1 <= '0; m_prev <= '0;
      m_en <= 8'hFF; m_esel <= 8'hFF; m_opt <= '0; m_cnt <= '0; m_wrap <= 1'b0;
    end else begin
      m_s0 <= pin_in; m_s1 <= m_s0; m_prev <= m_s1;
      if (wr_en && addr == 3'd0) m_en   <= wdata;
      if (wr_en && addr == 3'd1) m_esel <= wdata;
      if (wr_en && addr == 3'd3) m_opt  <= wdata;
      m_pend <= ((wr_en && addr == 3'd2) ? wdata : m_pend) | want_hit(m_s1, m_prev, m_esel);
      if (wr_en && addr == 3'd4) m_cnt <= wdata;
      else if (tick)             m_cnt <= m_cnt + 8'd1;
      m_wrap <= tick && !(wr_en && addr == 3'd4) && (m_cnt == 8'hFF);
    end
  end

  task automatic check(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // continuous comparison against the model (R6 R9 R10 R11 R2)
  always @(negedge clk) begin
    if (chk_on && rst_n && !done) begin
      check("R6/R9/R10", "irq", {7'd0, irq},
            {7'd0, want_wake(m_pend, m_en) | (m_wrap & m_opt[0])});
      check("R11", "wake", {7'd0, wake}, {7'd0, want_wake(m_pend, m_en)});
      check("R2", "rdata", rdata, want_read(addr));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); #1;
    addr = a; #0.5;
    check(req, "readback", rdata, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, 8'hFF, "R1");
    rd(3'd1, 8'hFF, "R1");
    rd(3'd3, 8'h00, "R1");
    rd(3'd4, 8'h00, "R1");
    check("R1", "irq", {7'd0, irq}, 8'd0);

    // R2 readback
    wr(3'd3, 8'h5A); rd(3'd3, 8'h5A, "R2");
    wr(3'd3, 8'h00);
    rd(3'd6, 8'h00, "R2");

    // clear pending before unmasking anything
    wr(3'd2, 8'h00);
    chk_on = 1;

    // R3 rising edge on pin 0, masked (R5)
    wr(3'd1, 8'hFE);
    addr = 3'd2;
    @(negedge clk); #1 pin_in[0] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R3", "pend before 3rd edge", rdata & 8'h01, 8'h00);
    @(posedge clk); #1;
    check("R3", "pend at 3rd edge", rdata & 8'h01, 8'h01);
    check("R5", "masked irq", {7'd0, irq}, 8'd0);
    check("R5", "masked wake", {7'd0, wake}, 8'd0);

    // R6 unmask pin 0
    wr(3'd0, 8'hFE);
    check("R6", "irq", {7'd0, irq}, 8'd1);
    check("R6", "wake", {7'd0, wake}, 8'd1);
    wr(3'd0, 8'hFF);

    // R8 wrong direction (rising on falling-select pin 1) sets nothing
    addr = 3'd2;
    @(negedge clk); #1 pin_in[1] = 1'b1;
    repeat (5) @(negedge clk); #1;
    check("R8", "rising ignored", rdata & 8'h02, 8'h00);
    // R4 falling edge on pin 1
    pin_in[1] = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    check("R4", "pend before 3rd edge", rdata & 8'h02, 8'h00);
    @(posedge clk); #1;
    check("R4", "pend at 3rd edge", rdata & 8'h02, 8'h02);

    // R7 clearing write collides with a falling edge on pin 2
    @(negedge clk); #1 pin_in[2] = 1'b1;
    repeat (5) @(negedge clk); #1;
    pin_in[2] = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    wr_en = 1'b1; addr = 3'd2; wdata = 8'h00;
    @(posedge clk); #1;
    wr_en = 1'b0;
    check("R7", "edge survives write", rdata, 8'h04);
    repeat (5) @(negedge clk); #1;
    check("R8", "sticky", rdata, 8'h04);

    // R9 timer wrap with enable
    wr(3'd2, 8'h00);
    wr(3'd4, 8'hFD);
    wr(3'd3, 8'h01);
    addr = 3'd4;
    tick = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk); #1;
    check("R9", "count wrapped", rdata, 8'h00);
    check("R9", "irq on wrap", {7'd0, irq}, 8'd1);
    check("R11", "wake on wrap", {7'd0, wake}, 8'd0);
    @(posedge clk); #1;
    check("R10", "no timer pending", {7'd0, irq}, 8'd0);
    tick = 1'b0;

    // R10 wrap with timer disabled
    wr(3'd3, 8'h00);
    wr(3'd4, 8'hFF);
    addr = 3'd4;
    tick = 1'b1;
    @(posedge clk); #1;
    tick = 1'b0;
    check("R10", "count wrapped", rdata, 8'h00);
    check("R10", "disabled irq", {7'd0, irq}, 8'd0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk); #1;
      if ($urandom % 3 == 0) pin_in = pin_in ^ 8'($urandom);
      tick  = ($urandom % 3 == 0);
      wr_en = ($urandom % 6 == 0);
      addr  = 3'($urandom % 6);
      wdata = 8'($urandom);
      if (wr_en && addr == 3'd2 && ($urandom % 2 == 0)) wdata = 8'h00;
    end
    @(negedge clk); #1 wr_en = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule